// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the bus-facing half of a small byte-wide register bank. It watches an I2C bus through synchronizers clocked by the system clock, recognises START, repeated START and STOP, and answers to one 7-bit device address. Part of that address is fixed and part comes from strap inputs. The write data and the register selection pass through an internal pointer. The register bank itself lives outside this block. The block reaches it through a plain port: a register address, write data with a one-cycle write strobe, and read data with a one-cycle read strobe.

A master sets the pointer with the first byte after a write control byte. Every later byte in that transfer is stored at the pointer. To read, the master sets the pointer, issues a repeated START and sends the address again with the read bit set. It then clocks out bytes for as long as it keeps acknowledging. The pointer advances after each byte and wraps at the last register. An input can freeze the pointer, so that a master can poll or overwrite one register over and over.

SDA is driven only through an active-low output enable. When the enable is low the pad pulls SDA low; otherwise the line floats high through the bus pull-up.

Top module: `i2c_regport_slave`

## Requirements
- R1: The device address is 7 bits: binary 0100 in the top four bits, then strap_i[2], strap_i[1] and strap_i[0]. It arrives MSB first in the first byte after a START, and the eighth bit is the direction bit (0 = write, 1 = read). When the address matches, the block pulls SDA low during the ninth clock.
- R2: If the address does not match, the block gives no acknowledge. It then never drives SDA and never writes a register until the next START.
- R3: In a write transfer, the byte after the control byte loads the pointer. A pointer byte above 0x0A loads 0x00. Each later byte is written to the register the pointer selects, and every byte is acknowledged.
- R4: With seq_dis_i = 0, the pointer advances by one after every data byte, written or transmitted. From 0x0A it wraps to 0x00.
- R5: With seq_dis_i = 1, the pointer does not move, so successive bytes write or read the same register.
- R6: A data byte cut short by a STOP or a repeated START is not written.
- R7: A read consists of a write of the control byte and the pointer, a repeated START, and the control byte with the direction bit set to 1. The block then sends the byte at the pointer, MSB first, and keeps sending further bytes while the master acknowledges each one.
- R8: After the master answers a read byte with a NACK, the block stops sending and leaves SDA released until the next START or STOP.
- R9: reg_we_o pulses for exactly one cycle for each byte written. reg_re_o pulses for exactly one cycle for each byte that is transmitted. The two strobes never pulse in the same cycle.
- R10: After reset, SDA is released, the pointer (reg_addr_o) is 0x00 and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe_n_o | output | 1 | Active-low enable that pulls SDA low |
| strap_i | input | 3 | Low address bits taken from board straps |
| seq_dis_i | input | 1 | 1 freezes the pointer, 0 lets it advance |
| reg_addr_o | output | 4 | Register pointer toward the register file |
| reg_wdata_o | output | 8 | Byte to be written |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Byte at reg_addr_o, combinational from the register file |
| reg_re_o | output | 1 | One-cycle strobe when a byte is loaded for transmission |

## Verification
The hardest situation to reach from the ports is a data byte cut off after only a few of its bits. Ordinary bus transfers never produce it. The bench creates it by clocking four or five bits of a data byte and then issuing a STOP, or a repeated START followed by a read of the same register. It then confirms that no write strobe appeared and that the register still returns its old value. The pointer wrap is reached by sweeping every start pointer, including values above the last register, with transfers that run past 0x0A. The address decoder is covered by a full sweep of all 128 addresses and all strap values.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

   // Protocol engine states
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } bus_state_e;

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_rp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_p, sda_p;
   logic              scl_s, sda_s;

   // Idle bus level is high, so all flops reset to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_s      = scl_q[STAGES-1];
   assign sda_s      = sda_q[STAGES-1];
   assign sda_o      = sda_s;
   assign scl_rise_o = scl_s & ~scl_p;
   assign scl_fall_o = ~scl_s & scl_p;
   assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
   parameter int unsigned NUM_REGS = 11,
   parameter int unsigned BYTE_W   = 8,
   localparam int unsigned PTR_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] load_val_i,
   input  logic              step_i,
   input  logic              seq_dis_i,
   output logic [PTR_W-1:0]  ptr_o
);

   localparam logic [PTR_W-1:0]  LAST_P = PTR_W'(NUM_REGS - 1);
   localparam logic [BYTE_W-1:0] LAST_B = BYTE_W'(NUM_REGS - 1);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load_i) begin
         ptr_q <= (load_val_i > LAST_B) ? '0 : load_val_i[PTR_W-1:0];
      end else if (step_i && !seq_dis_i) begin
         ptr_q <= (ptr_q == LAST_P) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

   // R4
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST_P);

   // R4
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !seq_dis_i && !load_i && ptr_q == LAST_P) |=> ptr_q == '0);

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && seq_dis_i && !load_i) |=> $stable(ptr_q));

   // R3
   ptr_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_val_i > LAST_B) |=> ptr_q == '0);

endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
   import i2c_rp_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned STRAP_W  = 3,
   parameter int unsigned DEV_BASE = 'h20,
   localparam int unsigned ADDR_W  = BYTE_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s_i,
   input  logic               scl_rise_i,
   input  logic               scl_fall_i,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [BYTE_W-1:0]  rdata_i,
   output logic               ptr_load_o,
   output logic [BYTE_W-1:0]  ptr_val_o,
   output logic               ptr_step_o,
   output logic               we_o,
   output logic [BYTE_W-1:0]  wdata_o,
   output logic               re_o,
   output logic               sda_oe_n_o
);

   localparam int unsigned      CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL   = CNT_W'(BYTE_W);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(DEV_BASE);

   bus_state_e        state_q;
   logic [BYTE_W-1:0] rx_q, tx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              rw_q, mack_q, oe_n_q;
   logic              byte_done, addr_hit, load_tx;
   logic [ADDR_W-1:0] my_addr;

   // Generate variant: all address bits strapped, or a fixed prefix plus straps
   generate
      if (STRAP_W >= ADDR_W) begin : g_all_strap
         assign my_addr = strap_i[ADDR_W-1:0];
      end else begin : g_prefix
         assign my_addr = {BASE_V[ADDR_W-1:STRAP_W], strap_i};
      end
   endgenerate

   always_comb begin
      byte_done  = scl_fall_i && (cnt_q == FULL);
      addr_hit   = (rx_q[BYTE_W-1:1] == my_addr);
      ptr_load_o = (state_q == ST_PTR) && byte_done;
      we_o       = (state_q == ST_WR) && byte_done;
      load_tx    = scl_fall_i && (((state_q == ST_ADDR_ACK) && rw_q) ||
                                  ((state_q == ST_RD_ACK) && mack_q));
      re_o       = load_tx;
      ptr_step_o = we_o || ((state_q == ST_RD_ACK) && scl_rise_i);
   end

   assign ptr_val_o  = rx_q;
   assign wdata_o    = rx_q;
   assign sda_oe_n_o = oe_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rx_q    <= '0;
         tx_q    <= '0;
         cnt_q   <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         oe_n_q  <= 1'b1;
      end else if (start_i) begin
         state_q <= ST_ADDR;
         cnt_q   <= '0;
         oe_n_q  <= 1'b1;
      end else if (stop_i) begin
         state_q <= ST_IDLE;
         oe_n_q  <= 1'b1;
      end else begin
         case (state_q)
            ST_ADDR, ST_PTR, ST_WR: begin
               if (scl_rise_i && cnt_q != FULL) begin
                  rx_q  <= {rx_q[BYTE_W-2:0], sda_s_i};
                  cnt_q <= cnt_q + 1'b1;
               end
               if (byte_done) begin
                  if (state_q == ST_ADDR) begin
                     if (addr_hit) begin
                        rw_q    <= rx_q[0];
                        oe_n_q  <= 1'b0;
                        state_q <= ST_ADDR_ACK;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     oe_n_q  <= 1'b0;
                     state_q <= (state_q == ST_PTR) ? ST_PTR_ACK : ST_WR_ACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall_i) begin
                  if (rw_q) begin
                     tx_q    <= rdata_i;
                     oe_n_q  <= rdata_i[BYTE_W-1];
                     cnt_q   <= CNT_W'(1);
                     state_q <= ST_RD;
                  end else begin
                     oe_n_q  <= 1'b1;
                     cnt_q   <= '0;
                     state_q <= ST_PTR;
                  end
               end
            end
            ST_PTR_ACK, ST_WR_ACK: begin
               if (scl_fall_i) begin
                  oe_n_q  <= 1'b1;
                  cnt_q   <= '0;
                  state_q <= ST_WR;
               end
            end
            ST_RD: begin
               if (scl_fall_i) begin
                  if (cnt_q == FULL) begin
                     oe_n_q  <= 1'b1;
                     state_q <= ST_RD_ACK;
                  end else begin
                     tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                     oe_n_q <= tx_q[BYTE_W-2];
                     cnt_q  <= cnt_q + 1'b1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_rise_i) begin
                  mack_q <= ~sda_s_i;
               end
               if (scl_fall_i) begin
                  if (mack_q) begin
                     tx_q    <= rdata_i;
                     oe_n_q  <= rdata_i[BYTE_W-1];
                     cnt_q   <= CNT_W'(1);
                     state_q <= ST_RD;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_o && re_o));

   // R9
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |=> !we_o);

   // R9
   re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      re_o |=> !re_o);

   // R2
   rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE || state_q == ST_ADDR || state_q == ST_PTR ||
       state_q == ST_WR) |-> sda_oe_n_o);

   // R8
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD_ACK && scl_fall_i && !mack_q) |=>
      (state_q == ST_IDLE && sda_oe_n_o));

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned NUM_REGS    = 11,
   parameter int unsigned STRAP_W     = 3,
   parameter int unsigned DEV_BASE    = 'h20,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PTR_W      = $clog2(NUM_REGS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_n_o,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               seq_dis_i,
   output logic [PTR_W-1:0]   reg_addr_o,
   output logic [BYTE_W-1:0]  reg_wdata_o,
   output logic               reg_we_o,
   input  logic [BYTE_W-1:0]  reg_rdata_i,
   output logic               reg_re_o
);

   generate
      if (BYTE_W < 4) begin : g_bad_byte
         $error("i2c_regport_slave: BYTE_W too small");
      end
      if (NUM_REGS < 2 || NUM_REGS > (1 << BYTE_W)) begin : g_bad_regs
         $error("i2c_regport_slave: NUM_REGS out of range");
      end
      if (STRAP_W < 1 || STRAP_W > BYTE_W - 1) begin : g_bad_strap
         $error("i2c_regport_slave: STRAP_W out of range");
      end
   endgenerate

   logic              sda_s, scl_rise, scl_fall, start_c, stop_c;
   logic              ptr_load, ptr_step;
   logic [BYTE_W-1:0] ptr_val;

   i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_c),
      .stop_o     (stop_c)
   );

   i2c_rp_engine #(
      .BYTE_W   (BYTE_W),
      .STRAP_W  (STRAP_W),
      .DEV_BASE (DEV_BASE)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s_i    (sda_s),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_c),
      .stop_i     (stop_c),
      .strap_i    (strap_i),
      .rdata_i    (reg_rdata_i),
      .ptr_load_o (ptr_load),
      .ptr_val_o  (ptr_val),
      .ptr_step_o (ptr_step),
      .we_o       (reg_we_o),
      .wdata_o    (reg_wdata_o),
      .re_o       (reg_re_o),
      .sda_oe_n_o (sda_oe_n_o)
   );

   i2c_rp_ptr #(
      .NUM_REGS (NUM_REGS),
      .BYTE_W   (BYTE_W)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ptr_load),
      .load_val_i (ptr_val),
      .step_i     (ptr_step),
      .seq_dis_i  (seq_dis_i),
      .ptr_o      (reg_addr_o)
   );

endmodule

// File: tb/tb_i2c_regport_slave.sv
module tb_i2c_regport_slave;

   localparam int Q    = 8;
   localparam int NREG = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       scl_m = 1'b1, sda_m = 1'b1, seq_dis = 1'b0;
   logic [2:0] strap = 3'b110;
   logic       sda_oe_n, reg_we, reg_re;
   logic [3:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   wire        sda_line = sda_m & sda_oe_n;

   logic [7:0] rf [0:NREG-1];
   logic [7:0] em [0:NREG-1];
   int we_cnt = 0, re_cnt = 0, drive_cnt = 0, cyc = 0;
   int checks = 0, errors = 0;

   i2c_regport_slave dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_oe_n_o  (sda_oe_n),
      .strap_i     (strap),
      .seq_dis_i   (seq_dis),
      .reg_addr_o  (reg_addr),
      .reg_wdata_o (reg_wdata),
      .reg_we_o    (reg_we),
      .reg_rdata_i (reg_rdata),
      .reg_re_o    (reg_re)
   );

   // Register file harness
   assign reg_rdata = (reg_addr < NREG) ? rf[reg_addr] : 8'h00;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
      end else begin
         if (reg_we && reg_addr < NREG) rf[reg_addr] <= reg_wdata;
         if (reg_we) we_cnt = we_cnt + 1;
         if (reg_re) re_cnt = re_cnt + 1;
         if (!sda_oe_n) drive_cnt = drive_cnt + 1;
      end
   end

   always @(posedge clk) begin
      if (cyc == 190000) begin
         errors = errors + 1;
         $display("FAIL watchdog: got timeout exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      checks = checks + 1;
      if (got !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: got %0h exp %0h", tag, got, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(Q);
      s = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(~give_ack, s);
   endtask

   function automatic logic [7:0] ctrl(input logic rw);
      return {4'b0100, strap, rw};
   endfunction

   function automatic int nxt(input int p);
      if (seq_dis) return p;
      return (p == NREG - 1) ? 0 : p + 1;
   endfunction

   task automatic compare_all(input string tag);
      for (int i = 0; i < NREG; i++) chk(tag, rf[i], em[i]);
   endtask

   task automatic write_seq(input int p, input int n, input int seed);
      logic ack;
      int   ep, w0;
      logic [7:0] d;
      w0 = we_cnt;
      bus_start();
      send_byte(ctrl(1'b0), ack); chk("R1 write ctrl ack", ack, 1);
      send_byte(8'(p), ack);      chk("R3 pointer ack", ack, 1);
      ep = (p > NREG - 1) ? 0 : p;
      for (int i = 0; i < n; i++) begin
         d = 8'((seed * 29 + i * 71 + 13) ^ 8'hA5);
         send_byte(d, ack);
         chk("R3 data ack", ack, 1);
         em[ep] = d;
         ep = nxt(ep);
      end
      bus_stop();
      chk("R9 write strobe count", we_cnt - w0, n);
      compare_all("R3 R4 register contents");
   endtask

   task automatic read_seq(input int p, input int n);
      logic ack;
      int   ep, r0;
      logic [7:0] d;
      r0 = re_cnt;
      bus_start();
      send_byte(ctrl(1'b0), ack); chk("R1 ctrl ack", ack, 1);
      send_byte(8'(p), ack);      chk("R3 pointer ack", ack, 1);
      bus_start();
      send_byte(ctrl(1'b1), ack); chk("R7 read ctrl ack", ack, 1);
      ep = (p > NREG - 1) ? 0 : p;
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, d);
         chk("R7 R4 read data", d, em[ep]);
         ep = nxt(ep);
      end
      bus_stop();
      chk("R9 read strobe count", re_cnt - r0, n);
   endtask

   initial begin
      logic ack, s;
      logic [7:0] d;
      int w0, r0, dr0;

      for (int i = 0; i < NREG; i++) em[i] = 8'h00;
      tick(5);
      // R10 reset state
      chk("R10 sda released", sda_oe_n, 1);
      chk("R10 pointer", reg_addr, 0);
      chk("R10 write strobe", reg_we, 0);
      chk("R10 read strobe", reg_re, 0);
      rst_n = 1'b1;
      tick(5);
      chk("R10 sda released after reset", sda_oe_n, 1);

      // R1 R2: every 7-bit address with a fixed strap
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({7'(a), 1'b0}, ack);
         bus_stop();
         chk("R1 R2 address sweep", ack, (7'(a) == {4'b0100, strap}) ? 1 : 0);
      end
      // R1: every strap value, matching and off-by-one-bit addresses
      for (int sv = 0; sv < 8; sv++) begin
         strap = 3'(sv);
         tick(2);
         bus_start();
         send_byte({4'b0100, 3'(sv), 1'b0}, ack);
         bus_stop();
         chk("R1 strap match", ack, 1);
         bus_start();
         send_byte({4'b0100, 3'(sv) ^ 3'b100, 1'b0}, ack);
         bus_stop();
         chk("R1 strap mismatch", ack, 0);
      end
      strap = 3'b110;
      tick(2);

      // R2: unaddressed transfer is ignored
      w0 = we_cnt; dr0 = drive_cnt;
      bus_start();
      send_byte({7'h27, 1'b0}, ack); chk("R2 no ack", ack, 0);
      send_byte(8'h01, ack);          chk("R2 pointer ignored", ack, 0);
      send_byte(8'hEE, ack);          chk("R2 data ignored", ack, 0);
      bus_stop();
      chk("R2 no write", we_cnt - w0, 0);
      chk("R2 sda never driven", drive_cnt - dr0, 0);
      compare_all("R2 registers untouched");

      // R3 R4 R7: every start pointer incl. values above the last register
      for (int p = 0; p < 13; p++) begin
         write_seq(p, 3, p);
         read_seq(p, 3);
      end

      // R4: long run across the wrap
      write_seq(0, 13, 40);
      read_seq(4, 13);

      // R5: frozen pointer
      seq_dis = 1'b1;
      tick(2);
      write_seq(5, 3, 77);
      read_seq(5, 4);
      seq_dis = 1'b0;
      tick(2);

      // R6: partial byte then STOP
      w0 = we_cnt;
      bus_start();
      send_byte(ctrl(1'b0), ack);
      send_byte(8'h03, ack);
      for (int i = 0; i < 4; i++) clk_bit(i[0], s);
      bus_stop();
      chk("R6 stop discards partial byte", we_cnt - w0, 0);
      compare_all("R6 registers after stop");

      // R6: partial byte then repeated START and read-back
      w0 = we_cnt;
      bus_start();
      send_byte(ctrl(1'b0), ack);
      send_byte(8'h04, ack);
      for (int i = 0; i < 5; i++) clk_bit(~i[0], s);
      bus_start();
      send_byte(ctrl(1'b1), ack); chk("R7 read after restart ack", ack, 1);
      recv_byte(1'b0, d);
      bus_stop();
      chk("R6 restart discards partial byte", we_cnt - w0, 0);
      chk("R6 register keeps old value", d, em[4]);

      // R8: master NACK ends transmission
      r0 = re_cnt;
      bus_start();
      send_byte(ctrl(1'b0), ack);
      send_byte(8'h02, ack);
      bus_start();
      send_byte(ctrl(1'b1), ack);
      recv_byte(1'b0, d);
      chk("R8 byte before nack", d, em[2]);
      dr0 = drive_cnt;
      for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
      chk("R8 sda released after nack", drive_cnt - dr0, 0);
      chk("R9 one strobe for one byte", re_cnt - r0, 1);
      bus_stop();

      tick(20);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule